// File: doc/BRIEF.md
# 100BASE-X Carrier Sense and Collision Detector

This block sits behind code-group alignment in a 100 Mb/s receive path. Once per symbol clock it takes one aligned 5-bit code group. It raises carrier sense when it sees the stream-start delimiter pair, /J/ then /K/. It drops carrier sense when it sees the stream-end delimiter pair, /T/ then /R/. It also drops carrier sense when an idle code group appears in the middle of a stream without that end pair. That early end also produces a one-cycle stream-error pulse.

The collision output is formed without a register. It combines carrier sense, the local transmit-active indication and a half-duplex mode input. Data decoding, descrambling and alignment are done elsewhere.

Top module: `pcs_carrier_detect`

## Requirements
- R1: While reset (rst_n low) is applied, and after it is released with no further input, crs_o, strm_err_o and col_o are all low.
- R2: The code groups used are J = 5'b11000, K = 5'b10001, T = 5'b01101, R = 5'b00111 and IDLE = 5'b11111. When a J is followed by a K on the next symbol clock, crs_o is high starting with the clock edge that samples the K.
- R3: A J whose next code group is not K leaves crs_o low, and the detector goes back to looking for J. A K with no J immediately before it also leaves crs_o low. J, J, K does start a stream.
- R4: In a stream, a T followed by an R takes crs_o low at the edge that samples the R, and strm_err_o stays low.
- R5: In a stream, an IDLE that is not the closing R of a T/R pair takes crs_o low at the edge that samples it. It also drives strm_err_o high for exactly one cycle.
- R6: In a stream, a T that is not followed by R, and any other non-IDLE code group, keeps crs_o high.
- R7: Outside a stream, T/R pairs and IDLE code groups have no effect: crs_o and strm_err_o stay low.
- R8: In half-duplex mode (half_duplex_i high), col_o is high in the same cycle in which both tx_active_i and crs_o are high, and is low otherwise, with no clock delay.
- R9: In full-duplex mode (half_duplex_i low), col_o is low whatever the activity.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Symbol clock |
| rst_n | input | 1 | Active-low synchronous reset |
| code_i | input | 5 | Aligned received code group |
| tx_active_i | input | 1 | Local transmitter active |
| half_duplex_i | input | 1 | 1 = half duplex, 0 = full duplex |
| crs_o | output | 1 | Carrier sense |
| col_o | output | 1 | Collision indication (combinational) |
| strm_err_o | output | 1 | One-cycle pulse on a stream ended by IDLE |

## Verification
The stream is tried with a clean J/K ... T/R frame, which separates a correct start from a correct end. A broken start (J, data, K), a lone K and a doubled J show that only the adjacent pair counts. A frame whose T is followed by data, and which later ends in bare IDLE, separates the clean end from the premature-end path and its error pulse. Delimiters and IDLE sent between frames confirm they are ignored. The collision output is swept over all transmit and duplex combinations both inside and outside a stream.

// File: rtl/pcs_carrier_pkg.sv
package pcs_carrier_pkg;
  localparam int unsigned SYM_W = 5;
  typedef logic [SYM_W-1:0] sym_t;

  localparam sym_t SYM_J    = 5'b11000;
  localparam sym_t SYM_K    = 5'b10001;
  localparam sym_t SYM_T    = 5'b01101;
  localparam sym_t SYM_R    = 5'b00111;
  localparam sym_t SYM_IDLE = 5'b11111;

  // adjacent-pair match: earlier symbol a, current symbol b
  function automatic logic pair_match(sym_t earlier, sym_t now_sym, sym_t a, sym_t b);
    return (earlier == a) && (now_sym == b);
  endfunction

  function automatic logic sym_is(sym_t s, sym_t ref_sym);
    return s == ref_sym;
  endfunction
endpackage

// File: rtl/pcs_pair_det.sv
module pcs_pair_det
  import pcs_carrier_pkg::*;
#(
  parameter sym_t FIRST  = SYM_J,
  parameter sym_t SECOND = SYM_K
) (
  input  logic clk,
  input  logic rst_n,
  input  sym_t sym_i,
  output logic hit_o
);
  sym_t prev_q;

  always_ff @(posedge clk) begin
    if (!rst_n) prev_q <= '0;
    else        prev_q <= sym_i;
  end

  assign hit_o = pair_match(prev_q, sym_i, FIRST, SECOND);
endmodule

// File: rtl/pcs_carrier_fsm.sv
module pcs_carrier_fsm (
  input  logic clk,
  input  logic rst_n,
  input  logic start_hit_i,
  input  logic end_hit_i,
  input  logic idle_hit_i,
  output logic crs_o,
  output logic err_o
);
  logic crs_q, err_q;
  logic crs_d, err_d;
  logic clean_end, early_end;

  assign clean_end = crs_q && end_hit_i;
  assign early_end = crs_q && !end_hit_i && idle_hit_i;

  always_comb begin
    crs_d = crs_q;
    err_d = 1'b0;
    if (!crs_q) begin
      crs_d = start_hit_i;
    end else if (clean_end) begin
      crs_d = 1'b0;
    end else if (early_end) begin
      crs_d = 1'b0;
      err_d = 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      crs_q <= 1'b0;
      err_q <= 1'b0;
    end else begin
      crs_q <= crs_d;
      err_q <= err_d;
    end
  end

  assign crs_o = crs_q;
  assign err_o = err_q;

  // R2
  jk_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!crs_q && start_hit_i) |=> crs_q);
  // R3
  crs_rise_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(crs_q) |-> $past(start_hit_i));
  // R4
  tr_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (crs_q && end_hit_i) |=> (!crs_q && !err_q));
  // R5
  idle_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (crs_q && idle_hit_i && !end_hit_i) |=> (!crs_q && err_q));
  // R5
  err_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    err_q |=> !err_q);
  // R6
  stream_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (crs_q && !end_hit_i && !idle_hit_i) |=> crs_q);
  // R7
  no_err_outside_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !crs_q |=> !err_q);
endmodule

// File: rtl/pcs_col_gen.sv
module pcs_col_gen (
  input  logic clk,
  input  logic rst_n,
  input  logic crs_i,
  input  logic tx_active_i,
  input  logic half_duplex_i,
  output logic col_o
);
  assign col_o = half_duplex_i & tx_active_i & crs_i;

  // R9
  fd_col_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !half_duplex_i |-> !col_o);
  // R8
  col_both_chk: assert property (@(posedge clk) disable iff (!rst_n)
    col_o |-> (tx_active_i && crs_i));
  // R8
  col_present_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (half_duplex_i && tx_active_i && crs_i) |-> col_o);
endmodule

// File: rtl/pcs_carrier_detect.sv
module pcs_carrier_detect
  import pcs_carrier_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic [SYM_W-1:0] code_i,
  input  logic             tx_active_i,
  input  logic             half_duplex_i,
  output logic             crs_o,
  output logic             col_o,
  output logic             strm_err_o
);
  logic jk_hit, tr_hit, idle_hit;
  logic crs_int;

  pcs_pair_det #(.FIRST(SYM_J), .SECOND(SYM_K)) u_start_det (
    .clk(clk), .rst_n(rst_n), .sym_i(code_i), .hit_o(jk_hit));

  pcs_pair_det #(.FIRST(SYM_T), .SECOND(SYM_R)) u_end_det (
    .clk(clk), .rst_n(rst_n), .sym_i(code_i), .hit_o(tr_hit));

  assign idle_hit = sym_is(code_i, SYM_IDLE);

  pcs_carrier_fsm u_fsm (
    .clk(clk), .rst_n(rst_n),
    .start_hit_i(jk_hit), .end_hit_i(tr_hit), .idle_hit_i(idle_hit),
    .crs_o(crs_int), .err_o(strm_err_o));

  pcs_col_gen u_col (
    .clk(clk), .rst_n(rst_n), .crs_i(crs_int),
    .tx_active_i(tx_active_i), .half_duplex_i(half_duplex_i), .col_o(col_o));

  assign crs_o = crs_int;

  // R1
  reset_quiet_chk: assert property (@(posedge clk)
    !rst_n |=> (!crs_o && !strm_err_o));
endmodule

// File: tb/pcs_carrier_detect_bench.sv
module pcs_carrier_detect_bench;
  localparam logic [4:0] CJ = 5'b11000, CK = 5'b10001, CT = 5'b01101,
                         CR = 5'b00111, CI = 5'b11111, CD = 5'b01010;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [4:0] code = CI;
  logic tx = 1'b0, hd = 1'b0;
  logic crs, col, serr;

  int errors = 0, checks = 0, cycles = 0;

  logic [1:0] q_exp[$];
  string      q_tag[$];

  logic [4:0] m_prev = 5'b0;
  logic       m_crs = 1'b0;

  always #4 clk = ~clk;

  pcs_carrier_detect u_pcs_carrier_detect (
    .clk(clk), .rst_n(rst_n), .code_i(code), .tx_active_i(tx),
    .half_duplex_i(hd), .crs_o(crs), .col_o(col), .strm_err_o(serr));

  task automatic check(input logic [1:0] act, input logic [1:0] exp, input string tag);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: got %b expected %b", tag, act, exp);
    end
  endtask

  // driver: present one symbol, check col, push expected registered outputs
  task automatic send(input logic [4:0] c, input logic t, input logic h, input string tag);
    logic nc, ne;
    @(negedge clk);
    code = c; tx = t; hd = h;
    #1;
    check({1'b0, col}, {1'b0, h & t & m_crs}, {tag, " col"});
    ne = m_crs && (c == CI) && !(m_prev == CT && c == CR);
    if (!m_crs) nc = (m_prev == CJ) && (c == CK);
    else        nc = !((m_prev == CT && c == CR) || c == CI);
    m_crs = nc; m_prev = c;
    q_exp.push_back({nc, ne});
    q_tag.push_back(tag);
  endtask

  task automatic sym(input logic [4:0] c, input string tag);
    send(c, 1'b0, 1'b0, tag);
  endtask

  // monitor
  always @(posedge clk) begin
    #2;
    if (q_exp.size() > 0) begin
      logic [1:0] e;
      string t;
      e = q_exp.pop_front();
      t = q_tag.pop_front();
      check({crs, serr}, e, t);
    end
  end

  // watchdog
  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000) begin
      errors++; checks++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    check({crs, serr}, 2'b00, "R1 in reset");
    check({1'b0, col}, 2'b00, "R1 col in reset");
    rst_n = 1'b1;
    @(negedge clk); #1;
    check({crs, serr}, 2'b00, "R1 after reset");

    // clean frame
    sym(CI, "R7 idle"); sym(CI, "R7 idle");
    sym(CJ, "R2 J"); sym(CK, "R2 K");
    sym(CD, "R6 data"); sym(CD, "R6 data");
    sym(CT, "R4 T"); sym(CR, "R4 R");
    sym(CI, "R4 idle after"); sym(CI, "R7 idle");

    // broken starts
    sym(CJ, "R3 J"); sym(CD, "R3 data"); sym(CK, "R3 K late");
    sym(CK, "R3 lone K"); sym(CI, "R3 idle");
    sym(CJ, "R3 J1"); sym(CJ, "R3 J2"); sym(CK, "R3 K after JJ");

    // T without R, then premature idle
    sym(CT, "R6 T alone"); sym(CD, "R6 data after T");
    sym(CJ, "R6 J in stream"); sym(CK, "R6 K in stream");
    sym(CI, "R5 early idle"); sym(CI, "R5 pulse over"); sym(CI, "R7 idle");

    // T then idle directly
    sym(CJ, "R2 J"); sym(CK, "R2 K"); sym(CT, "R6 T");
    sym(CI, "R5 T then idle"); sym(CD, "R5 after");

    // delimiters outside stream
    sym(CT, "R7 T out"); sym(CR, "R7 R out"); sym(CI, "R7 idle out"); sym(CD, "R7 data out");

    // collision sweep outside and inside a stream
    send(CD, 1'b1, 1'b1, "R8 hd tx no crs");
    send(CJ, 1'b1, 1'b0, "R9 fd tx");
    send(CK, 1'b0, 1'b1, "R8 hd no tx");
    send(CD, 1'b1, 1'b1, "R8 hd tx crs");
    send(CD, 1'b1, 1'b0, "R9 fd tx crs");
    send(CD, 1'b0, 1'b0, "R9 fd idle tx");
    send(CD, 1'b0, 1'b1, "R8 hd crs no tx");
    send(CT, 1'b1, 1'b1, "R8 hd tx T");
    send(CR, 1'b1, 1'b1, "R8 hd tx R");
    send(CI, 1'b1, 1'b1, "R8 after end");

    repeat (3) @(negedge clk);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule